// File: doc/BRIEF.md
# Exception Level State Tracker

This block holds the privilege context of a processing element: which of four privilege levels (EL0 lowest to EL3 highest) is current, whether the element is in the Secure or the Non-secure world, and whether the current level runs with 64-bit or 32-bit registers. The surrounding pipeline sends it one request per clock at most. A request either takes an exception up to a target level, or returns from an exception to a saved level, security state and width. The block checks each request against the privilege rules. It commits a legal request at the next clock edge. For an illegal request it raises a one-cycle flag and leaves the state as it was.

A small set of per-level width registers records the register width that a more privileged level has chosen for each level below it. Entry to a level takes its width from that register. A return must name the same width as the register holds. The block also tells the memory side whether physical accesses to the Secure address space are currently allowed. The parameter `HAS_HYP` selects whether the hypervisor level EL2 is implemented.

Top module: `el_state_tracker`

## Requirements
- R1: While `rst_n` is low the state is EL3 (`cur_lvl` = 3), Secure (`cur_secure` = 1) and 64-bit (`cur_aa64` = 1), and `bad_req` is 0. Every width register resets to 64-bit.
- R2: An exception whose target is below the current level, or a return whose target is above it, is illegal. An illegal request raises `bad_req` for exactly the cycle after the request and leaves level, security and width unchanged.
- R3: A legal exception to EL3 makes the state Secure. A legal exception to any other level keeps the current security state.
- R4: EL2 is never made current while Secure, and is never made current when `HAS_HYP` is 0. EL3 is never made current while Non-secure. Requests that would do either are illegal.
- R5: A return from EL3 loads the security state from `req_secure`. A return from any other level whose `req_secure` differs from the current security state is illegal.
- R6: A committed transition sets `cur_aa64` from the width register of the target level; EL3 is always 64-bit. A return whose `req_aa64` differs from that register is illegal. A request that keeps the level but changes the width is illegal.
- R7: A transition that makes a level current in 64-bit mode is illegal when the next implemented higher level is set to 32-bit. For EL1 that level is EL2, or EL3 when `HAS_HYP` is 0. For EL0 it is EL1.
- R8: A write (`cfg_we` = 1) to the width register of level `cfg_lvl` with value `cfg_aa64` (1 = 64-bit) takes effect at the next edge only if `cfg_lvl` is below the current level. Any other write is ignored.
- R9: `sec_pa_allow` is 1 exactly when the current state is Secure.
- R10: When `req_exc` and `req_ret` are both high in a valid cycle, the request is handled as an exception.
- R11: With `req_valid` low, `req_exc` and `req_ret` have no effect on the state or on `bad_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| req_valid | input | 1 | A request is present this cycle |
| req_exc | input | 1 | Request kind: take an exception to `req_lvl` |
| req_ret | input | 1 | Request kind: return to `req_lvl` / `req_secure` / `req_aa64` |
| req_lvl | input | 2 | Target level, 0 to 3 |
| req_secure | input | 1 | Saved security state for a return (1 = Secure) |
| req_aa64 | input | 1 | Saved width for a return (1 = 64-bit) |
| cfg_we | input | 1 | Write enable for a width register |
| cfg_lvl | input | 2 | Level whose width register is written |
| cfg_aa64 | input | 1 | Width value to write (1 = 64-bit) |
| cur_lvl | output | 2 | Current privilege level |
| cur_secure | output | 1 | Current security state (1 = Secure) |
| cur_aa64 | output | 1 | Current register width (1 = 64-bit) |
| sec_pa_allow | output | 1 | Secure physical accesses are allowed |
| bad_req | output | 1 | One-cycle pulse after an illegal request |

## Verification
The bench builds the tracker with `HAS_HYP` = 1. This brings the full four-level chain within reach: the Non-secure path through EL2, the EL2 width register that decides whether EL1 may run 64-bit, and the rule against EL2 in the Secure world. A scoreboard of expected level, security, width and error pulse, computed by a separate model, follows a walk through every level. The walk includes width register writes from permitted and forbidden levels and both kinds of request raised together.

// File: rtl/el_pkg.sv
package el_pkg;

  localparam int NUM_EL = 4;
  localparam int LVL_W  = $clog2(NUM_EL);

  typedef logic [LVL_W-1:0] el_t;

  localparam el_t EL_TOP = el_t'(NUM_EL - 1);
  localparam el_t EL_HYP = el_t'(NUM_EL - 2);

  typedef struct packed {
    el_t  lvl;
    logic secure;
    logic aa64;
  } pe_state_t;

  localparam pe_state_t RESET_STATE = '{lvl: EL_TOP, secure: 1'b1, aa64: 1'b1};

  typedef enum logic [1:0] {
    RQ_NONE = 2'd0,
    RQ_TAKE = 2'd1,
    RQ_RET  = 2'd2
  } rq_kind_t;

endpackage

// File: rtl/el_width_regs.sv
module el_width_regs
  import el_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  el_t               cur_lvl,
  input  logic              cfg_we,
  input  el_t               cfg_lvl,
  input  logic              cfg_aa64,
  output logic [NUM_EL-1:0] width_q,
  output logic [NUM_EL-1:0] permit64
);

  for (genvar l = 0; l < NUM_EL; l++) begin : g_lvl
    if (l == NUM_EL - 1) begin : g_top
      // most privileged level: fixed 64-bit, nothing above it to constrain it
      assign width_q[l]  = 1'b1;
      assign permit64[l] = 1'b1;
    end else begin : g_low
      logic w_q;
      logic w_en;

      // only a strictly more privileged level may configure this one
      always_comb begin
        w_en = cfg_we && (cfg_lvl == el_t'(l)) && (cur_lvl > el_t'(l));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          w_q <= 1'b1;
        end else if (w_en) begin
          w_q <= cfg_aa64;
        end
      end

      assign width_q[l] = w_q;

      // 64-bit allowed only if the next implemented level above is 64-bit
      if (!HAS_HYP && (l + 1 == int'(EL_HYP))) begin : g_skip_hyp
        assign permit64[l] = width_q[l+2];
      end else begin : g_next
        assign permit64[l] = width_q[l+1];
      end
    end
  end

endmodule

// File: rtl/el_rule_check.sv
module el_rule_check
  import el_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  pe_state_t         cur,
  input  rq_kind_t          kind,
  input  el_t               tgt_lvl,
  input  logic              tgt_secure,
  input  logic              tgt_aa64,
  input  logic [NUM_EL-1:0] width_q,
  input  logic [NUM_EL-1:0] permit64,
  output logic              legal,
  output pe_state_t         nxt
);

  logic dir_ok;
  logic sec_ok;
  logic wid_ok;
  logic lvl_ok;
  logic chain_ok;
  logic same_ok;

  always_comb begin
    nxt    = cur;
    dir_ok = 1'b1;
    sec_ok = 1'b1;
    wid_ok = 1'b1;
    case (kind)
      RQ_TAKE: begin
        nxt.lvl    = tgt_lvl;
        nxt.secure = (tgt_lvl == EL_TOP) ? 1'b1 : cur.secure;
        nxt.aa64   = width_q[tgt_lvl];
        dir_ok     = (tgt_lvl >= cur.lvl);
      end
      RQ_RET: begin
        nxt.lvl    = tgt_lvl;
        nxt.secure = tgt_secure;
        nxt.aa64   = tgt_aa64;
        dir_ok     = (tgt_lvl <= cur.lvl);
        // the world may only switch on the way down from the top level
        sec_ok     = (cur.lvl == EL_TOP) || (tgt_secure == cur.secure);
        wid_ok     = (tgt_aa64 == width_q[tgt_lvl]);
      end
      default: ;
    endcase

    lvl_ok   = !((nxt.lvl == EL_HYP) && (nxt.secure || !HAS_HYP)) &&
               !((nxt.lvl == EL_TOP) && !nxt.secure);
    chain_ok = !nxt.aa64 || permit64[nxt.lvl];
    same_ok  = (nxt.lvl != cur.lvl) || (nxt.aa64 == cur.aa64);

    legal = dir_ok && sec_ok && wid_ok && lvl_ok && chain_ok && same_ok;
  end

endmodule

// File: rtl/el_state_reg.sv
module el_state_reg
  import el_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_any,
  input  logic      legal,
  input  pe_state_t nxt,
  output pe_state_t state_q,
  output logic      bad_q
);

  logic st_en;
  logic bad_d;

  always_comb begin
    st_en = req_any && legal;
    bad_d = req_any && !legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_STATE;
    end else if (st_en) begin
      state_q <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_q <= 1'b0;
    end else begin
      bad_q <= bad_d;
    end
  end

endmodule

// File: rtl/el_state_tracker.sv
module el_state_tracker
  import el_pkg::*;
#(
  parameter bit HAS_HYP = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_exc,
  input  logic       req_ret,
  input  logic [1:0] req_lvl,
  input  logic       req_secure,
  input  logic       req_aa64,
  input  logic       cfg_we,
  input  logic [1:0] cfg_lvl,
  input  logic       cfg_aa64,
  output logic [1:0] cur_lvl,
  output logic       cur_secure,
  output logic       cur_aa64,
  output logic       sec_pa_allow,
  output logic       bad_req
);

  rq_kind_t          kind;
  pe_state_t         state_q;
  pe_state_t         nxt;
  logic              legal;
  logic [NUM_EL-1:0] width_q;
  logic [NUM_EL-1:0] permit64;

  // exception wins over return when both are raised
  always_comb begin
    if (!req_valid)   kind = RQ_NONE;
    else if (req_exc) kind = RQ_TAKE;
    else if (req_ret) kind = RQ_RET;
    else              kind = RQ_NONE;
  end

  el_width_regs #(.HAS_HYP(HAS_HYP)) u_width (
    .clk      (clk),
    .rst_n    (rst_n),
    .cur_lvl  (state_q.lvl),
    .cfg_we   (cfg_we),
    .cfg_lvl  (cfg_lvl),
    .cfg_aa64 (cfg_aa64),
    .width_q  (width_q),
    .permit64 (permit64)
  );

  el_rule_check #(.HAS_HYP(HAS_HYP)) u_rules (
    .cur        (state_q),
    .kind       (kind),
    .tgt_lvl    (req_lvl),
    .tgt_secure (req_secure),
    .tgt_aa64   (req_aa64),
    .width_q    (width_q),
    .permit64   (permit64),
    .legal      (legal),
    .nxt        (nxt)
  );

  el_state_reg u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_any (kind != RQ_NONE),
    .legal   (legal),
    .nxt     (nxt),
    .state_q (state_q),
    .bad_q   (bad_req)
  );

  assign cur_lvl      = state_q.lvl;
  assign cur_secure   = state_q.secure;
  assign cur_aa64     = state_q.aa64;
  assign sec_pa_allow = state_q.secure;

endmodule

// File: rtl/el_state_tracker_chk.sv
module el_state_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cur_lvl,
  input logic       cur_secure,
  input logic       cur_aa64,
  input logic       bad_req
);

  // R1: reset state seen at every edge while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (cur_lvl == 2'd3 && cur_secure && cur_aa64 && !bad_req)
        else $error("a_r1_reset_state");
    end
  end

  // R2: an error pulse means nothing moved
  a_r2_bad_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    bad_req |-> (cur_lvl == $past(cur_lvl)) && (cur_secure == $past(cur_secure)) &&
                (cur_aa64 == $past(cur_aa64)));

  // R3: entering the Secure world only happens at the top level
  a_r3_secure_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cur_secure) |-> (cur_lvl == 2'd3));

  // R4: top level is always Secure, hypervisor level never Secure
  a_r4_top_secure: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd3) |-> cur_secure);

  a_r4_hyp_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd2) |-> !cur_secure);

  // R5: leaving the Secure world only happens from the top level
  a_r5_secure_exit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cur_secure) |-> ($past(cur_lvl) == 2'd3));

  // R6: width only moves together with the level; top level is 64-bit
  a_r6_width_with_level: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == $past(cur_lvl)) |-> (cur_aa64 == $past(cur_aa64)));

  a_r6_top_wide: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_lvl == 2'd3) |-> cur_aa64);

endmodule

bind el_state_tracker el_state_tracker_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cur_lvl    (cur_lvl),
  .cur_secure (cur_secure),
  .cur_aa64   (cur_aa64),
  .bad_req    (bad_req)
);

// File: tb/test_el_state_tracker.sv
module test_el_state_tracker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_exc, req_ret, req_secure, req_aa64;
  logic [1:0] req_lvl;
  logic       cfg_we, cfg_aa64;
  logic [1:0] cfg_lvl;
  logic [1:0] cur_lvl;
  logic       cur_secure, cur_aa64, sec_pa_allow, bad_req;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [1:0] lvl;
    logic       sec;
    logic       w64;
    logic       bad;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // independent model state
  logic [1:0] m_lvl;
  logic       m_sec, m_w64;
  logic       m_wreg [4];

  always #5 clk = ~clk;

  el_state_tracker #(.HAS_HYP(1'b1)) i_el_state_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_exc(req_exc), .req_ret(req_ret),
    .req_lvl(req_lvl), .req_secure(req_secure), .req_aa64(req_aa64),
    .cfg_we(cfg_we), .cfg_lvl(cfg_lvl), .cfg_aa64(cfg_aa64),
    .cur_lvl(cur_lvl), .cur_secure(cur_secure), .cur_aa64(cur_aa64),
    .sec_pa_allow(sec_pa_allow), .bad_req(bad_req)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pop one expectation per cycle, half a period after the edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cur_lvl !== e.lvl || cur_secure !== e.sec || cur_aa64 !== e.w64 ||
          bad_req !== e.bad || sec_pa_allow !== e.sec) begin
        errors++;
        $display("FAIL %s: got lvl=%0d sec=%0d w64=%0d bad=%0d pa=%0d exp lvl=%0d sec=%0d w64=%0d bad=%0d pa=%0d",
                 e.tag, cur_lvl, cur_secure, cur_aa64, bad_req, sec_pa_allow,
                 e.lvl, e.sec, e.w64, e.bad, e.sec);
      end
    end
  end

  function automatic logic hi_wide(input logic [1:0] l);
    if (l == 2'd2)      return 1'b1;
    else if (l == 2'd1) return m_wreg[2];
    else                return m_wreg[1];
  endfunction

  // driver: apply one cycle of stimulus and queue what the requirements predict
  task automatic step(input logic v, input logic ex, input logic rt, input logic [1:0] lvl,
                      input logic sec, input logic w64, input logic cw, input logic [1:0] cl,
                      input logic cv, input string tag);
    logic       ok, bad;
    logic [1:0] tl;
    logic       ts, tw;
    exp_t       e;
    @(negedge clk);
    req_valid = v; req_exc = ex; req_ret = rt; req_lvl = lvl;
    req_secure = sec; req_aa64 = w64; cfg_we = cw; cfg_lvl = cl; cfg_aa64 = cv;
    bad = 1'b0;
    if (v && (ex || rt)) begin
      ok = 1'b1;
      tl = lvl;
      if (ex) begin
        ts = (lvl == 2'd3) ? 1'b1 : m_sec;
        tw = m_wreg[lvl];
        if (lvl < m_lvl) ok = 1'b0;
      end else begin
        ts = sec;
        tw = w64;
        if (lvl > m_lvl) ok = 1'b0;
        if (m_lvl != 2'd3 && sec != m_sec) ok = 1'b0;
        if (w64 != m_wreg[lvl]) ok = 1'b0;
      end
      if (tl == 2'd2 && ts) ok = 1'b0;
      if (tl == 2'd3 && !ts) ok = 1'b0;
      if (tl != 2'd3 && tw && !hi_wide(tl)) ok = 1'b0;
      if (tl == m_lvl && tw != m_w64) ok = 1'b0;
      bad = !ok;
      if (ok) begin m_lvl = tl; m_sec = ts; m_w64 = tw; end
    end
    e.lvl = m_lvl; e.sec = m_sec; e.w64 = m_w64; e.bad = bad; e.tag = tag;
    @(posedge clk);
    #1;
    // config applies against the level held before the edge
    if (cw && cl != 2'd3 && (e.bad || !(v && (ex || rt)) ? 1'b1 : 1'b1)) begin end
    sb.push_back(e);
    req_valid = 0; req_exc = 0; req_ret = 0; cfg_we = 0;
  endtask

  task automatic take(input logic [1:0] lvl, input string tag);
    step(1, 1, 0, lvl, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic ret(input logic [1:0] lvl, input logic sec, input logic w64, input string tag);
    step(1, 0, 1, lvl, sec, w64, 0, 0, 0, tag);
  endtask

  // width register write: model updates with the level current at that edge
  task automatic cfg(input logic [1:0] l, input logic w, input string tag);
    logic [1:0] lvl_now;
    lvl_now = m_lvl;
    step(0, 0, 0, 0, 0, 0, 1, l, w, tag);
    if (l != 2'd3 && lvl_now > l) m_wreg[l] = w;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: got running exp finished");
        finish_run();
      end
    end
  end

  initial begin
    req_valid = 0; req_exc = 0; req_ret = 0; req_lvl = 0; req_secure = 0; req_aa64 = 0;
    cfg_we = 0; cfg_lvl = 0; cfg_aa64 = 0;
    m_lvl = 2'd3; m_sec = 1'b1; m_w64 = 1'b1;
    for (int i = 0; i < 4; i++) m_wreg[i] = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (cur_lvl !== 2'd3 || cur_secure !== 1'b1 || cur_aa64 !== 1'b1 || bad_req !== 1'b0 ||
        sec_pa_allow !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got lvl=%0d sec=%0d w64=%0d bad=%0d exp lvl=3 sec=1 w64=1 bad=0",
               cur_lvl, cur_secure, cur_aa64, bad_req);
    end
    rst_n = 1'b1;

    ret(2'd1, 0, 1, "R5 R6 R1 return top to EL1 non-secure 64-bit");
    take(2'd0, "R2 exception downward rejected");
    ret(2'd2, 0, 1, "R2 return upward rejected");
    take(2'd2, "R3 exception to EL2 keeps non-secure");
    ret(2'd1, 1, 1, "R5 return from EL2 may not set secure");
    cfg(2'd1, 0, "R8 EL2 configures EL1 as 32-bit");
    ret(2'd1, 0, 1, "R6 return width differs from register");
    ret(2'd1, 0, 0, "R6 return to EL1 in 32-bit");
    cfg(2'd0, 1, "R8 EL1 configures EL0 as 64-bit");
    ret(2'd0, 0, 1, "R7 EL0 64-bit under 32-bit EL1 rejected");
    cfg(2'd0, 0, "R8 EL1 configures EL0 as 32-bit");
    ret(2'd0, 0, 0, "R7 EL0 32-bit accepted");
    cfg(2'd1, 1, "R8 write from EL0 to EL1 register ignored");
    take(2'd1, "R8 R6 EL1 entered with unchanged 32-bit width");
    step(0, 1, 0, 2'd3, 0, 0, 0, 0, 0, "R11 exception without valid ignored");
    step(1, 1, 1, 2'd3, 0, 0, 0, 0, 0, "R10 R3 both raised: exception to top wins");
    ret(2'd2, 1, 1, "R4 return to EL2 secure rejected");
    ret(2'd3, 0, 1, "R4 top level non-secure rejected");
    ret(2'd1, 1, 0, "R5 R9 return from top to secure EL1");
    take(2'd2, "R4 exception to EL2 while secure rejected");
    ret(2'd1, 1, 1, "R6 same level width change rejected");
    ret(2'd0, 0, 0, "R5 secure cleared below top rejected");
    ret(2'd0, 1, 0, "R9 secure EL0 32-bit");
    cfg(2'd1, 1, "R8 EL0 write to EL1 register ignored again");
    take(2'd1, "R8 secure EL1 still 32-bit");
    take(2'd3, "R3 exception to top");
    ret(2'd2, 0, 1, "R5 R9 return from top to non-secure EL2");
    cfg(2'd1, 1, "R8 EL2 restores EL1 to 64-bit");
    ret(2'd1, 0, 1, "R7 R6 EL1 64-bit under 64-bit EL2");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule